// File: doc/BRIEF.md
# Sticky Write-Lock Register File

This block is a small byte-wide configuration register file with a single-cycle read/write port. It holds a bank of general configuration registers plus one lock register. Each address has a protect attribute fixed when the design is built. While the lock is clear, every implemented register takes writes. Once software sets the lock bit, writes to protected addresses are dropped without any indication. Reads continue to work as before.

The lock is a one-way switch. Writes can set it but no write can clear it. The lock register is always treated as protected, so software cannot write it again after locking. The only way to release the lock is a hardware reset. Unprotected registers stay writable throughout, and addresses that are not implemented read as zero and discard writes.

Top module: `slk_regfile`

## Requirements
- R1: After a synchronous reset, every implemented register reads 0x00 and the lock is clear.
- R2: The lock register is at address 0xEF. Bit 0 is the lock flag. Bits 7..1 always read 0, so writing 0xFF while unlocked reads back as 0x01.
- R3: While unlocked, a write to a protected register is stored. With the default parameters, addresses 0x00–0x07 are protected.
- R4: While locked, a write to a protected register leaves its value unchanged.
- R5: Unprotected registers accept writes whether or not the lock is set. With the default parameters, addresses 0x08–0x0F are unprotected.
- R6: Once set, the lock stays set. Writing 0x00 to 0xEF does not clear it.
- R7: A hardware reset clears the lock, and protected registers then accept writes again.
- R8: A write to an unimplemented address (default: 0x10–0xEE and 0xF0–0xFF) is ignored, and reading such an address returns 0x00.
- R9: Writing a value with bit 0 clear to 0xEF while unlocked leaves the lock clear.
- R10: `rd_data` follows `addr` combinationally. A write becomes visible only after the rising edge on which `wr_en` is high.
- R11: When `wr_en` is low, no register changes, whatever the values on `addr` and `wr_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| addr | input | 8 | Byte address for both read and write |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_data | output | 8 | Read data for `addr`, combinational |

## Verification
The hardest state to reach from the ports is the one after the lock is set: from there, only a reset can lead anywhere new. The bench therefore first fills protected and unprotected registers with known patterns while unlocked, and it probes the lock with a write that has bit 0 clear. Only then does it set the lock. Next it tries to overwrite protected registers and to clear the lock, and finally it applies a reset to show that the frozen state is released.

// File: rtl/slk_pkg.sv
package slk_pkg;

  localparam int unsigned SLK_ADDR_W    = 8;
  localparam int unsigned SLK_DATA_W    = 8;
  localparam int unsigned SLK_NUM_REGS  = 16;
  localparam logic [SLK_ADDR_W-1:0] SLK_LOCK_ADDR = 8'hEF;

  // One bit per address; set means writes are dropped while locked.
  localparam logic [(1<<SLK_ADDR_W)-1:0] SLK_PROT_MASK =
    {{((1<<SLK_ADDR_W)-8){1'b0}}, 8'hFF};

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_BANK = 2'd1,
    SEL_LOCK = 2'd2
  } slk_sel_e;

endpackage

// File: rtl/slk_addr_decode.sv
module slk_addr_decode
  import slk_pkg::*;
#(
  parameter int unsigned ADDR_W    = SLK_ADDR_W,
  parameter int unsigned NUM_REGS  = SLK_NUM_REGS,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = SLK_LOCK_ADDR,
  parameter logic [(1<<ADDR_W)-1:0] PROT_MASK = SLK_PROT_MASK,
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output slk_sel_e          sel,
  output logic [IDX_W-1:0]  idx,
  output logic              prot
);

  logic in_bank;

  always_comb begin
    in_bank = ({1'b0, addr} < (ADDR_W+1)'(NUM_REGS));
    if (addr == LOCK_ADDR)  sel = SEL_LOCK;
    else if (in_bank)       sel = SEL_BANK;
    else                    sel = SEL_NONE;
    idx  = addr[IDX_W-1:0];
    // The lock register is protected no matter what the mask says.
    prot = PROT_MASK[addr] | (addr == LOCK_ADDR);
  end

endmodule

// File: rtl/slk_lock_ctrl.sv
module slk_lock_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  output logic lock_q
);

  // Can only go 0 -> 1; reset is the single way back.
  always_ff @(posedge clk) begin
    if (rst) lock_q <= 1'b0;
    else if (set_req) lock_q <= 1'b1;
  end

endmodule

// File: rtl/slk_reg_bank.sv
module slk_reg_bank #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs[g] <= '0;
      else if (we && (idx == IDX_W'(g))) regs[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx == IDX_W'(i)) rdata = regs[i];
    end
  end

endmodule

// File: rtl/slk_regfile.sv
module slk_regfile
  import slk_pkg::*;
#(
  parameter int unsigned ADDR_W    = SLK_ADDR_W,
  parameter int unsigned DATA_W    = SLK_DATA_W,
  parameter int unsigned NUM_REGS  = SLK_NUM_REGS,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = SLK_LOCK_ADDR,
  parameter logic [(1<<ADDR_W)-1:0] PROT_MASK = SLK_PROT_MASK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  slk_sel_e          sel;
  logic [IDX_W-1:0]  idx;
  logic              prot;
  logic              lock_q;
  logic              wr_accept;
  logic              lock_set;
  logic              bank_we;
  logic [DATA_W-1:0] bank_rd;

  slk_addr_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .LOCK_ADDR(LOCK_ADDR),
    .PROT_MASK(PROT_MASK)
  ) u_dec (
    .addr(addr),
    .sel (sel),
    .idx (idx),
    .prot(prot)
  );

  always_comb begin
    wr_accept = wr_en && (sel != SEL_NONE) && !(prot && lock_q);
    lock_set  = wr_accept && (sel == SEL_LOCK) && wr_data[0];
    bank_we   = wr_accept && (sel == SEL_BANK);
  end

  slk_lock_ctrl u_lock (
    .clk    (clk),
    .rst    (rst),
    .set_req(lock_set),
    .lock_q (lock_q)
  );

  slk_reg_bank #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS)
  ) u_bank (
    .clk  (clk),
    .rst  (rst),
    .we   (bank_we),
    .idx  (idx),
    .wdata(wr_data),
    .rdata(bank_rd)
  );

  always_comb begin
    unique case (sel)
      SEL_LOCK: rd_data = {{(DATA_W-1){1'b0}}, lock_q};
      SEL_BANK: rd_data = bank_rd;
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/slk_regfile_chk.sv
module slk_regfile_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_REGS  = 16,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'hEF,
  parameter logic [(1<<ADDR_W)-1:0] PROT_MASK = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_lsb,
  input logic              wr_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              lock_q,
  input logic              wr_accept
);

  logic impl_a, prot_a, lock_a;
  always_comb begin
    lock_a = (addr == LOCK_ADDR);
    impl_a = lock_a || ({1'b0, addr} < (ADDR_W+1)'(NUM_REGS));
    prot_a = lock_a || PROT_MASK[addr];
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> !lock_q);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    lock_a |-> (rd_data[DATA_W-1:1] == '0 && rd_data[0] == lock_q));

  assert_prot_blocked_R4: assert property (@(posedge clk) disable iff (rst)
    (lock_q && prot_a) |-> !wr_accept);

  assert_unprot_open_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && impl_a && !prot_a) |-> wr_accept);

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);

  assert_unimpl_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !impl_a |-> (rd_data == '0 && !wr_accept));

  assert_zero_keeps_open_R9: assert property (@(posedge clk) disable iff (rst)
    (!lock_q && wr_en && lock_a && !wr_lsb) |=> !lock_q);

  assert_no_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> !wr_accept);

endmodule

bind slk_regfile slk_regfile_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .NUM_REGS (NUM_REGS),
  .LOCK_ADDR(LOCK_ADDR),
  .PROT_MASK(PROT_MASK)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .addr     (addr),
  .wr_lsb   (wr_data[0]),
  .wr_en    (wr_en),
  .rd_data  (rd_data),
  .lock_q   (lock_q),
  .wr_accept(wr_accept)
);

// File: tb/sim_slk_regfile.sv
`timescale 1ns/1ps
module sim_slk_regfile;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic       wr_en = 1'b0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  slk_regfile u0 (
    .clk(clk), .rst(rst), .addr(addr),
    .wr_data(wr_data), .wr_en(wr_en), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    rd_check("R1 reg00", 8'h00, 8'h00);
    rd_check("R1 reg0F", 8'h0F, 8'h00);
    rd_check("R1 lock", 8'hEF, 8'h00);
  endtask

  task automatic t_unlocked_writes();
    for (int i = 0; i < 16; i++) wr(8'(i), 8'(8'hA0 + i));
    for (int i = 0; i < 8; i++) rd_check("R3 protected write", 8'(i), 8'(8'hA0 + i));
    for (int i = 8; i < 16; i++) rd_check("R5 unprotected write", 8'(i), 8'(8'hA0 + i));
  endtask

  task automatic t_unimpl();
    wr(8'h10, 8'h5A);
    rd_check("R8 unimpl 10", 8'h10, 8'h00);
    wr(8'hF0, 8'h33);
    rd_check("R8 unimpl F0", 8'hF0, 8'h00);
    rd_check("R8 unimpl EE", 8'hEE, 8'h00);
    rd_check("R8 bank intact", 8'h00, 8'hA0);
  endtask

  task automatic t_lock_zero_write();
    wr(8'hEF, 8'hFE);
    rd_check("R9 lock stays clear", 8'hEF, 8'h00);
    wr(8'h01, 8'h11);
    rd_check("R9 still writable", 8'h01, 8'h11);
  endtask

  task automatic t_wr_en_low();
    @(negedge clk);
    addr = 8'h02; wr_data = 8'hEE; wr_en = 1'b0;
    @(negedge clk);
    #1;
    check("R11 no strobe", rd_data, 8'hA2);
    addr = 8'hEF; wr_data = 8'hFF;
    @(negedge clk);
    #1;
    check("R11 lock untouched", rd_data, 8'h00);
  endtask

  task automatic t_timing();
    @(negedge clk);
    addr = 8'h03; wr_data = 8'h77; wr_en = 1'b1;
    #1;
    check("R10 before edge", rd_data, 8'hA3);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    check("R10 after edge", rd_data, 8'h77);
    addr = 8'h09;
    #1;
    check("R10 comb read", rd_data, 8'hA9);
  endtask

  task automatic t_lock_set();
    wr(8'hEF, 8'hFF);
    rd_check("R2 reserved bits zero", 8'hEF, 8'h01);
  endtask

  task automatic t_locked();
    wr(8'h00, 8'h99);
    rd_check("R4 protected frozen 00", 8'h00, 8'hA0);
    wr(8'h07, 8'h99);
    rd_check("R4 protected frozen 07", 8'h07, 8'hA7);
    wr(8'h08, 8'h42);
    rd_check("R5 unprotected while locked", 8'h08, 8'h42);
    wr(8'h0F, 8'h24);
    rd_check("R5 unprotected 0F", 8'h0F, 8'h24);
  endtask

  task automatic t_sticky();
    wr(8'hEF, 8'h00);
    rd_check("R6 lock sticky", 8'hEF, 8'h01);
    wr(8'hEF, 8'hFE);
    rd_check("R6 lock sticky 2", 8'hEF, 8'h01);
  endtask

  task automatic t_hard_reset();
    do_reset();
    rd_check("R7 lock released", 8'hEF, 8'h00);
    wr(8'h05, 8'h5C);
    rd_check("R7 protected writable", 8'h05, 8'h5C);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_unlocked_writes();
    t_unimpl();
    t_lock_zero_write();
    t_wr_en_low();
    t_timing();
    t_lock_set();
    t_locked();
    t_sticky();
    t_hard_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule